// File: doc/BRIEF.md
# Direction-Selected Synchronous Byte FIFO

This block is a single-clock first-in first-out buffer for bytes. It smooths out bursts between a producer and a consumer that share one clock, storing up to 256 entries in a flip-flop array. Instead of separate push and pop enables it has one direction line. On every clock cycle that line picks a write (high) or a read (low). Reads and writes never happen in the same cycle.

A write takes the byte on the data input and places it behind the newest entry. A read takes the oldest entry and registers it onto the data output, where it appears after the clock edge. Four status flags are decoded from the occupancy: empty, full, nearly full and nearly empty. The two threshold levels are fixed by parameters. A write while full and a read while empty are both dropped without side effects. An active-low asynchronous reset returns the buffer to its empty state.

Top module: `dirsel_byte_fifo`

## Requirements
- R1: With `wrNotRd` = 1 and the buffer not full, the byte on `dataIn` is stored as the newest entry at the clock edge, and the occupancy rises by one.
- R2: With `wrNotRd` = 0 and the buffer not empty, the oldest entry is removed at the clock edge and appears on `dataOut` right after that same edge. `dataOut` holds that value until the next successful read.
- R3: A write attempted while `isFull` = 1 is dropped. Stored contents, order and occupancy are unchanged.
- R4: A read attempted while `isEmpty` = 1 is dropped. `dataOut` keeps its previous value and occupancy stays 0.
- R5: `isEmpty` is 1 exactly when the occupancy is 0.
- R6: `isFull` is 1 exactly when the occupancy equals the capacity of 256.
- R7: `nearFull` is 1 exactly when the occupancy is at least `NEAR_FULL_LVL` (default 240).
- R8: `nearEmpty` is 1 exactly when the occupancy is at most `NEAR_EMPTY_LVL` (default 16).
- R9: While `rstN` = 0, and without waiting for a clock, the buffer is emptied and `dataOut` is 0. This gives `isEmpty` = 1, `nearEmpty` = 1, `isFull` = 0 and `nearFull` = 0.
- R10: Entries come out in the order they were written, including when the storage positions wrap from the last slot back to the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrNotRd | input | 1 | 1 selects a write this cycle, 0 selects a read |
| dataIn | input | 8 | Byte to store on a write |
| dataOut | output | 8 | Byte last read, registered |
| isEmpty | output | 1 | No entries held |
| isFull | output | 1 | All 256 entries held |
| nearEmpty | output | 1 | Occupancy at or below the low threshold |
| nearFull | output | 1 | Occupancy at or above the high threshold |

## Verification
The hardest case to reach from the ports is a wrap of the storage positions while the buffer is partly filled, together with attempts to write while full at the exact capacity boundary. The direction line forces a read on every cycle it is low, so the buffer only fills on long unbroken runs of writes. The stimulus therefore applies a run of 259 writes to hit full and overrun it. It then drains past empty, and after that applies a long biased random mix that keeps the occupancy near the middle while both positions circle the array several times. An asynchronous reset is also dropped between clock edges while the buffer holds data.

// File: rtl/dirfifo_pkg.sv
package dirfifo_pkg;
  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic wrStb;  // store dataIn at the write slot
    logic rdStb;  // load the read slot into the output register
  } fifoStb_t;
endpackage

// File: rtl/dirfifo_ctrl.sv
module dirfifo_ctrl
  import dirfifo_pkg::*;
#(
  parameter int DEPTH          = 256,
  parameter int NEAR_FULL_LVL  = 240,
  parameter int NEAR_EMPTY_LVL = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrNotRd,
  output fifoStb_t      stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          isEmpty,
  output logic          isFull,
  output logic          nearEmpty,
  output logic          nearFull
);
  localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_HI   = CW'(NEAR_FULL_LVL);
  localparam logic [CW-1:0] CNT_LO   = CW'(NEAR_EMPTY_LVL);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [CW-1:0] fillCnt;
  logic [AW-1:0] wrPtr, rdPtr;

  // Status decode from occupancy.
  always_comb begin
    isEmpty   = (fillCnt == '0);
    isFull    = (fillCnt == CNT_MAX);
    nearFull  = (fillCnt >= CNT_HI);
    nearEmpty = (fillCnt <= CNT_LO);
  end

  // Qualified strobes: a write while full or a read while empty is dropped.
  always_comb begin
    stb.wrStb = wrNotRd & ~isFull;
    stb.rdStb = ~wrNotRd & ~isEmpty;
  end

  assign wrAddr = wrPtr;
  assign rdAddr = rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fillCnt <= '0;
    end else begin
      if (stb.wrStb) begin
        wrPtr   <= (wrPtr == LAST_IDX) ? '0 : wrPtr + 1'b1;
        fillCnt <= fillCnt + 1'b1;
      end
      if (stb.rdStb) begin
        rdPtr   <= (rdPtr == LAST_IDX) ? '0 : rdPtr + 1'b1;
        fillCnt <= fillCnt - 1'b1;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && wrNotRd) |=> (fillCnt == CNT_MAX && $stable(wrPtr))); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (isEmpty && !wrNotRd) |=> (fillCnt == '0 && $stable(rdPtr))); // R4
  AST_WRITE_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    (wrNotRd && !isFull) |=> (fillCnt == $past(fillCnt) + 1'b1)); // R1
  AST_READ_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    (!wrNotRd && !isEmpty) |=> (fillCnt == $past(fillCnt) - 1'b1)); // R2
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(isEmpty && isFull)); // R5
  AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr == rdPtr) |-> (isEmpty || isFull)); // R10
endmodule

// File: rtl/dirfifo_dpath.sv
module dirfifo_dpath
  import dirfifo_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStb_t          stb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  logic [DATA_W-1:0] slotQ [DEPTH];

  // One register per slot, loaded when the write strobe points at it.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    always_ff @(posedge clk) begin
      if (stb.wrStb && wrAddr == AW'(gi)) slotQ[gi] <= dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          dataOut <= '0;
    else if (stb.rdStb) dataOut <= slotQ[rdAddr];
  end

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdStb |=> $stable(dataOut)); // R4
  AST_NO_DOUBLE_OP: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.wrStb && stb.rdStb)); // R1
endmodule

// File: rtl/dirsel_byte_fifo.sv
module dirsel_byte_fifo
  import dirfifo_pkg::*;
#(
  parameter int DEPTH          = 256,
  parameter int DATA_W         = 8,
  parameter int NEAR_FULL_LVL  = 240,
  parameter int NEAR_EMPTY_LVL = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrNotRd,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              isEmpty,
  output logic              isFull,
  output logic              nearEmpty,
  output logic              nearFull
);
  localparam int AW = $clog2(DEPTH);

  fifoStb_t      stb;
  logic [AW-1:0] wrAddr, rdAddr;

  dirfifo_ctrl #(
    .DEPTH(DEPTH), .NEAR_FULL_LVL(NEAR_FULL_LVL), .NEAR_EMPTY_LVL(NEAR_EMPTY_LVL)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrNotRd(wrNotRd), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .isEmpty(isEmpty), .isFull(isFull), .nearEmpty(nearEmpty), .nearFull(nearFull)
  );

  dirfifo_dpath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .dataIn(dataIn), .dataOut(dataOut)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |-> (isEmpty && nearEmpty && !isFull && !nearFull && dataOut == '0)); // R9
  AST_FULL_IMPLIES_NEAR: assert property (@(posedge clk) disable iff (!rstN)
    isFull |-> nearFull); // R7
  AST_EMPTY_IMPLIES_NEAR: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty |-> nearEmpty); // R8
endmodule

// File: tb/test_dirsel_byte_fifo.sv
`timescale 1ns/1ps
module test_dirsel_byte_fifo;
  localparam int CAP = 256;
  localparam int HI  = 240;
  localparam int LO  = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrNotRd = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dataOut;
  logic       isEmpty, isFull, nearEmpty, nearFull;

  always #2 clk = ~clk;  // 250 MHz

  dirsel_byte_fifo i_dirsel_byte_fifo (
    .clk(clk), .rstN(rstN), .wrNotRd(wrNotRd), .dataIn(dataIn),
    .dataOut(dataOut), .isEmpty(isEmpty), .isFull(isFull),
    .nearEmpty(nearEmpty), .nearFull(nearFull)
  );

  // Behavioural reference.
  byte unsigned refQ[$];
  logic [7:0]   refOut = 8'h00;
  int nVec = 0, nBad = 0;
  bit done = 1'b0;

  task automatic chk(string req, string what, int act, int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(string tag);
    int n = refQ.size();
    chk("R2/R4", {tag, " dataOut"}, dataOut, refOut);
    chk("R5", {tag, " isEmpty"}, isEmpty, n == 0);
    chk("R6", {tag, " isFull"}, isFull, n == CAP);
    chk("R7", {tag, " nearFull"}, nearFull, n >= HI);
    chk("R8", {tag, " nearEmpty"}, nearEmpty, n <= LO);
  endtask

  // One cycle: drive at negedge, update model at posedge, compare at next negedge.
  task automatic step(bit w, logic [7:0] d, string tag);
    wrNotRd = w;
    dataIn  = d;
    @(posedge clk);
    if (w) begin
      if (refQ.size() < CAP) refQ.push_back(d);  // R1, R3
    end else if (refQ.size() > 0) begin
      refOut = refQ.pop_front();                 // R2, R10; else R4
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    #1;
    compareAll("R9 reset");
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    // R4: reads on empty buffer
    step(1'b0, 8'h00, "R4 read-empty");
    step(1'b0, 8'h00, "R4 read-empty");
    // R1/R2: a few writes then reads, plus one read past empty
    for (int i = 0; i < 10; i++) step(1'b1, 8'(8'hA0 + i), "R1 write");
    for (int i = 0; i < 11; i++) step(1'b0, 8'h00, "R2 read");
    // R6/R7/R3: fill to capacity and overrun by three
    for (int i = 0; i < CAP + 3; i++) step(1'b1, 8'(i * 7 + 3), "R3 fill");
    chk("R6", "full after fill", isFull, 1);
    // R8/R5: drain past empty
    for (int i = 0; i < CAP + 2; i++) step(1'b0, 8'h00, "R10 drain");
    chk("R5", "empty after drain", isEmpty, 1);
    // R10: mixed traffic, positions wrap many times
    for (int i = 0; i < 3000; i++) begin
      bit w = ($urandom_range(0, 99) < ((refQ.size() < 120) ? 60 : 40));
      step(w, 8'($urandom), "R10 mix");
    end
    // R9: asynchronous reset between edges with data held
    for (int i = 0; i < 30; i++) step(1'b1, 8'(i), "R1 refill");
    #0.5 rstN = 1'b0;
    #0.5;
    refQ.delete();
    refOut = 8'h00;
    compareAll("R9 async");
    @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 8'h00, "R9 read after reset");
    step(1'b1, 8'h5C, "R1 post-reset write");
    step(1'b0, 8'h00, "R2 post-reset read");
    chk("R2", "last byte", dataOut, 8'h5C);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule